// File: doc/BRIEF.md
# Byte/Word Selectable ROM Read Port

This block models the read side of a one-time-programmable memory at clock-cycle level. A word array sits behind an active-high chip enable and an active-high output enable. When both are active, a read returns the addressed word. When chip enable is low the port is in standby. When only output enable is low the outputs are disabled. Each 8-bit output lane has its own tri-state enable, so a pad ring or a bus model can drive or float the lanes separately.

A byte-mode strap switches the port from 16-bit to 8-bit output. In byte mode the upper lane is never driven. The pin that carries the top data bit in word mode serves as the least significant byte address, and it picks which half of the stored word appears on the lower lane. A separate flag stands for a high voltage on one address line and selects identification mode. In that mode a manufacturer code or a device code replaces array data, chosen by address bit 0. A backdoor load port programs the array with one-time-programmable semantics. All outputs are registered, so a read shows up one clock after its controls are sampled.

Top module: `rom_rdport`

## Requirements
- R1: With chip_en low, the read that follows has lane_oe = 2'b00 and standby = 1, whatever out_en is.
- R2: With chip_en high and out_en low, the read that follows has lane_oe = 2'b00 and standby = 0.
- R3: In word mode (byte_mode = 0) with both enables high, lane_oe = 2'b11 and data_out equals the whole stored word at addr.
- R4: In byte mode (byte_mode = 1), lane_oe[1] is always 0 and data_out[15:8] is 0; only lane 0 (lane_oe = 2'b01) is driven during a read.
- R5: In byte mode, byte_sel_in = 1 puts stored bits 15..8 on data_out[7:0], and byte_sel_in = 0 puts stored bits 7..0 there.
- R6: With id_hv = 1 during a read, addr[0] = 0 returns the manufacturer code 16'h00C2 and addr[0] = 1 returns the device code (parameter DEV_CODE, default 16'hB800), in place of array data. In byte mode the code's bytes are steered as in R5.
- R7: During an identification read, id_addr_err is 1 exactly when an address bit other than bit 0 and bit ID_BIT (default 9) is set, and the code is still returned. Outside identification reads id_addr_err is 0.
- R8: After reset every array word reads 16'hFFFF.
- R9: A load (load_en = 1) clears each stored bit whose load_data bit is 0 and leaves the other bits unchanged, so a cleared bit never returns to 1.
- R10: Outputs reflect the controls and address sampled at the previous rising clock edge: one cycle of read latency.
- R11: The data bits of a lane whose lane_oe bit is 0 read 0. In reset, lane_oe = 0, standby = 1, data_out = 0 and id_addr_err = 0.
- R12: In word mode byte_sel_in has no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chip_en | input | 1 | Chip enable, active high |
| out_en | input | 1 | Output enable, active high |
| byte_mode | input | 1 | Strap: 1 selects byte output, 0 selects word output |
| byte_sel_in | input | 1 | Byte address LSB in byte mode; carried on the top data pin |
| id_hv | input | 1 | High-voltage flag on address line ID_BIT; selects identification mode |
| addr | input | ADDR_W | Word address |
| load_en | input | 1 | Backdoor program strobe |
| load_addr | input | ADDR_W | Backdoor program address |
| load_data | input | 16 | Backdoor program data; 0 bits are cleared in the array |
| data_out | output | 16 | Registered read data |
| lane_oe | output | 2 | Per-lane tri-state enable: bit 0 for bits 7..0, bit 1 for bits 15..8 |
| standby | output | 1 | Registered standby indication |
| id_addr_err | output | 1 | Identification read with an illegal address |

## Verification
The bench sweeps every address of the default array in three passes. The first pass runs in the blank state and tells a true all-ones erase apart from stale or zero contents. The second reads an address-derived pattern in word mode and in both byte halves, which separates wrong lane steering, swapped halves and address aliasing. The third reads the same words after a second load pass, which shows that loading only clears bits. The enable combinations are applied at regularly spaced addresses with both strap values, to separate standby from output disable. Identification reads cover legal addresses, a set ID line bit and illegal addresses in both modes, which separates code selection from error flagging.

// File: rtl/rom_rdport_pkg.sv
package rom_rdport_pkg;

    localparam int LANE_W  = 8;
    localparam int LANES   = 2;
    localparam int WORD_W  = LANE_W * LANES;

    typedef enum logic [1:0] {
        RD_STBY  = 2'd0,
        RD_OFF   = 2'd1,
        RD_ARRAY = 2'd2,
        RD_IDENT = 2'd3
    } rd_mode_e;

    typedef struct packed {
        logic [WORD_W-1:0] data;
        logic [LANES-1:0]  oe;
        logic              standby;
        logic              id_err;
    } port_state_t;

endpackage

// File: rtl/rom_cell_array.sv
module rom_cell_array
    import rom_rdport_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_en,
    input  logic [ADDR_W-1:0] prog_addr,
    input  logic [WORD_W-1:0] prog_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_word
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [WORD_W-1:0] cells_q [DEPTH];

    // Programming can only pull bits low; reset models the erased state.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                cells_q[i] <= '1;
            end
        end else if (prog_en) begin
            cells_q[prog_addr] <= cells_q[prog_addr] & prog_data;
        end
    end

    assign rd_word = cells_q[rd_addr];

endmodule

// File: rtl/rom_mode_dec.sv
module rom_mode_dec
    import rom_rdport_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int ID_BIT = 9
) (
    input  logic              chip_en,
    input  logic              out_en,
    input  logic              id_hv,
    input  logic [ADDR_W-1:0] addr,
    output rd_mode_e          mode,
    output logic              id_err
);

    localparam logic [ADDR_W-1:0] ONE_A     = {{(ADDR_W-1){1'b0}}, 1'b1};
    localparam logic [ADDR_W-1:0] ID_IGNORE = ONE_A | (ONE_A << ID_BIT);

    always_comb begin
        if (!chip_en) begin
            mode = RD_STBY;
        end else if (!out_en) begin
            mode = RD_OFF;
        end else if (id_hv) begin
            mode = RD_IDENT;
        end else begin
            mode = RD_ARRAY;
        end
        id_err = (mode == RD_IDENT) && ((addr & ~ID_IGNORE) != '0);
    end

endmodule

// File: rtl/rom_lane_steer.sv
module rom_lane_steer
    import rom_rdport_pkg::*;
(
    input  rd_mode_e          mode,
    input  logic              byte_mode,
    input  logic              byte_sel,
    input  logic [WORD_W-1:0] src_word,
    output logic [WORD_W-1:0] lane_data,
    output logic [LANES-1:0]  lane_en
);

    logic reading;
    assign reading = (mode == RD_ARRAY) || (mode == RD_IDENT);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        if (g == 0) begin : g_low
            // Lane 0 carries either half in byte mode.
            logic [LANE_W-1:0] pick;
            assign pick = (byte_mode && byte_sel) ? src_word[WORD_W-1 -: LANE_W]
                                                  : src_word[LANE_W-1:0];
            assign lane_en[g]   = reading;
            assign lane_data[g*LANE_W +: LANE_W] = reading ? pick : '0;
        end else begin : g_high
            assign lane_en[g]   = reading && !byte_mode;
            assign lane_data[g*LANE_W +: LANE_W] =
                (reading && !byte_mode) ? src_word[g*LANE_W +: LANE_W] : '0;
        end
    end

endmodule

// File: rtl/rom_rdport.sv
module rom_rdport
    import rom_rdport_pkg::*;
#(
    parameter int              ADDR_W   = 10,
    parameter int              ID_BIT   = 9,
    parameter logic [15:0]     MFR_CODE = 16'h00C2,
    parameter logic [15:0]     DEV_CODE = 16'hB800
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chip_en,
    input  logic              out_en,
    input  logic              byte_mode,
    input  logic              byte_sel_in,
    input  logic              id_hv,
    input  logic [ADDR_W-1:0] addr,
    input  logic              load_en,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic [15:0]       load_data,
    output logic [15:0]       data_out,
    output logic [1:0]        lane_oe,
    output logic              standby,
    output logic              id_addr_err
);

    rd_mode_e          mode;
    logic              id_err;
    logic [WORD_W-1:0] arr_word;
    logic [WORD_W-1:0] src_word;
    logic [WORD_W-1:0] lane_data;
    logic [LANES-1:0]  lane_en;
    port_state_t       st_d, st_q;

    rom_cell_array #(.ADDR_W(ADDR_W)) u_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .prog_en   (load_en),
        .prog_addr (load_addr),
        .prog_data (load_data),
        .rd_addr   (addr),
        .rd_word   (arr_word)
    );

    rom_mode_dec #(.ADDR_W(ADDR_W), .ID_BIT(ID_BIT)) u_dec (
        .chip_en (chip_en),
        .out_en  (out_en),
        .id_hv   (id_hv),
        .addr    (addr),
        .mode    (mode),
        .id_err  (id_err)
    );

    assign src_word = (mode == RD_IDENT) ? (addr[0] ? DEV_CODE : MFR_CODE) : arr_word;

    rom_lane_steer u_steer (
        .mode      (mode),
        .byte_mode (byte_mode),
        .byte_sel  (byte_sel_in),
        .src_word  (src_word),
        .lane_data (lane_data),
        .lane_en   (lane_en)
    );

    always_comb begin
        st_d         = st_q;
        st_d.data    = lane_data;
        st_d.oe      = lane_en;
        st_d.standby = (mode == RD_STBY);
        st_d.id_err  = id_err;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.data    <= '0;
            st_q.oe      <= '0;
            st_q.standby <= 1'b1;
            st_q.id_err  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign data_out    = st_q.data;
    assign lane_oe     = st_q.oe;
    assign standby     = st_q.standby;
    assign id_addr_err = st_q.id_err;

endmodule

// File: rtl/rom_rdport_chk.sv
module rom_rdport_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        chip_en,
    input logic        out_en,
    input logic        byte_mode,
    input logic        id_hv,
    input logic [15:0] data_out,
    input logic [1:0]  lane_oe,
    input logic        standby,
    input logic        id_addr_err
);

    AST_STBY_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
        standby |-> (lane_oe == 2'b00)); // R1

    AST_STBY_FOLLOWS_CE: assert property (@(posedge clk) disable iff (!rst_n)
        !chip_en |=> standby); // R1

    AST_DISABLE_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
        (chip_en && !out_en) |=> (lane_oe == 2'b00 && !standby)); // R2

    AST_BYTE_UPPER_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
        byte_mode |=> !lane_oe[1]); // R4

    AST_LOW_LANE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !lane_oe[0] |-> (data_out[7:0] == 8'h00)); // R11

    AST_HIGH_LANE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !lane_oe[1] |-> (data_out[15:8] == 8'h00)); // R11

    AST_ERR_NEEDS_ID: assert property (@(posedge clk) disable iff (!rst_n)
        !(chip_en && out_en && id_hv) |=> !id_addr_err); // R7

    AST_READ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (chip_en && out_en) |=> lane_oe[0]); // R10

endmodule

bind rom_rdport rom_rdport_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .chip_en     (chip_en),
    .out_en      (out_en),
    .byte_mode   (byte_mode),
    .id_hv       (id_hv),
    .data_out    (data_out),
    .lane_oe     (lane_oe),
    .standby     (standby),
    .id_addr_err (id_addr_err)
);

// File: tb/tb_rom_rdport.sv
`timescale 1ns/1ps
module tb_rom_rdport;

    localparam int          AW    = 10;
    localparam int          DEPTH = 1 << AW;
    localparam logic [15:0] MFR   = 16'h00C2;
    localparam logic [15:0] DEV   = 16'hB800;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          chip_en = 1'b0, out_en = 1'b0, byte_mode = 1'b0;
    logic          byte_sel_in = 1'b0, id_hv = 1'b0, load_en = 1'b0;
    logic [AW-1:0] addr = '0, load_addr = '0;
    logic [15:0]   load_data = '0;
    logic [15:0]   data_out;
    logic [1:0]    lane_oe;
    logic          standby, id_addr_err;

    int total = 0;
    int bad   = 0;
    logic [15:0] model [DEPTH];

    always #2.5 clk = ~clk;

    rom_rdport dut (
        .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .out_en(out_en),
        .byte_mode(byte_mode), .byte_sel_in(byte_sel_in), .id_hv(id_hv),
        .addr(addr), .load_en(load_en), .load_addr(load_addr),
        .load_data(load_data), .data_out(data_out), .lane_oe(lane_oe),
        .standby(standby), .id_addr_err(id_addr_err)
    );

    task automatic check(input string req, input logic [19:0] act, input logic [19:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act={data,oe,sb,err}=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic load(input logic [AW-1:0] a, input logic [15:0] d);
        @(negedge clk);
        chip_en = 1'b0; load_en = 1'b1; load_addr = a; load_data = d;
        @(posedge clk);
        #1;
        load_en = 1'b0;
        model[a] = model[a] & d;
    endtask

    // Drive one read, then sample just after the edge that registers it (R10).
    task automatic rd(input logic ce, input logic oe, input logic bm, input logic bs,
                      input logic hv, input logic [AW-1:0] a, input string req);
        logic [15:0] src, ed;
        logic [1:0]  eo;
        logic        es, ee;
        @(negedge clk);
        chip_en = ce; out_en = oe; byte_mode = bm; byte_sel_in = bs; id_hv = hv; addr = a;
        @(posedge clk);
        #1;
        src = hv ? (a[0] ? DEV : MFR) : model[a];
        ed = '0; eo = 2'b00; es = !ce; ee = 1'b0;
        if (ce && oe) begin
            if (bm) begin
                eo = 2'b01;
                ed = {8'h00, bs ? src[15:8] : src[7:0]};
            end else begin
                eo = 2'b11;
                ed = src;
            end
            ee = hv && ((a & ~(10'h201)) != '0);
        end
        check(req, {data_out, lane_oe, standby, id_addr_err}, {ed, eo, es, ee});
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) model[i] = 16'hFFFF;
        #12;
        // R11: reset state
        check("R11 reset", {data_out, lane_oe, standby, id_addr_err}, {16'h0, 2'b00, 1'b1, 1'b0});
        @(negedge clk);
        rst_n = 1'b1;

        // R8: blank array, word and byte reads
        for (int a = 0; a < DEPTH; a++) begin
            rd(1, 1, 0, 0, 0, AW'(a), "R8 blank word");
            if (a % 16 == 0) rd(1, 1, 1, a[4], 0, AW'(a), "R8 blank byte");
        end

        // R9: first program pass with address-derived pattern
        for (int a = 0; a < DEPTH; a++) load(AW'(a), 16'((a * 40503) ^ 16'hA5C3));

        // R3 R12 R4 R5: full sweep of word and both byte halves
        for (int a = 0; a < DEPTH; a++) begin
            rd(1, 1, 0, a[0], 0, AW'(a), "R3 R12 word read");
            rd(1, 1, 1, 0, 0, AW'(a), "R4 R5 byte low");
            rd(1, 1, 1, 1, 0, AW'(a), "R4 R5 byte high");
        end

        // R9: second pass, ones must not set cleared bits
        for (int a = 0; a < DEPTH; a += 5) load(AW'(a), 16'(~(a * 7919)));
        for (int a = 0; a < DEPTH; a += 5) rd(1, 1, 0, 0, 0, AW'(a), "R9 program clears only");

        // R1 R2 R10: enable combinations, then a read right after
        for (int a = 0; a < DEPTH; a += 64) begin
            rd(0, 0, a[6], 0, 0, AW'(a), "R1 standby oe low");
            rd(0, 1, a[6], 1, 0, AW'(a), "R1 standby oe high");
            rd(1, 0, a[6], 1, 0, AW'(a), "R2 output disable");
            rd(1, 1, a[6], 1, 0, AW'(a), "R10 read after disable");
            rd(0, 1, 0, 0, 1, AW'(a), "R1 standby with id flag");
        end

        // R6 R7: identification reads
        rd(1, 1, 0, 0, 1, 10'h000, "R6 mfr word");
        rd(1, 1, 0, 0, 1, 10'h001, "R6 dev word");
        rd(1, 1, 0, 0, 1, 10'h200, "R7 id line bit legal");
        rd(1, 1, 0, 0, 1, 10'h201, "R7 id line bit legal dev");
        rd(1, 1, 1, 0, 1, 10'h000, "R6 mfr byte low");
        rd(1, 1, 1, 1, 1, 10'h000, "R6 mfr byte high");
        rd(1, 1, 1, 0, 1, 10'h001, "R6 dev byte low");
        rd(1, 1, 1, 1, 1, 10'h001, "R6 dev byte high");
        for (int b = 1; b < AW; b++) begin
            rd(1, 1, 0, 0, 1, AW'(1 << b), "R7 single illegal bit");
            rd(1, 1, 1, 1, 1, AW'((1 << b) | 1), "R7 illegal bit byte dev");
        end
        rd(1, 1, 0, 0, 1, 10'h3FF, "R7 all bits set");
        rd(1, 0, 0, 0, 1, 10'h002, "R7 no flag when disabled");
        rd(1, 1, 0, 0, 0, 10'h002, "R7 no flag array read");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #900000;
        total++;
        bad++;
        $display("FAIL watchdog expired act=running exp=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule